// File: doc/BRIEF.md
# Single-Frame Capture Arm Controller

This block decides when one camera frame is allowed into an external frame FIFO. A host pulses a capture request at any time. The block waits for the next frame boundary, raises the FIFO write-enable there, holds it for exactly one whole frame, and drops it at the following boundary. When it drops, the block signals that the capture is complete. The block never acts on pixel data. It only gates the write strobe.

Frame boundaries are the falling edges of the vertical sync input, and line starts are the rising edges of the horizontal reference input. Both inputs are asynchronous and pass through a synchroniser chain of configurable depth before edge detection. Alongside the gating, the block counts line starts within each frame. At every boundary it latches that count as the line total of the frame that just ended, so the host can confirm the frame geometry. The host reads completion through a query strobe. The answer is returned one cycle later, and a positive answer consumes the completion flag.

Top module: `frame_capture_arm`

## Requirements
- R1: A one-cycle pulse on `cap_req` makes `busy` read 1 on the following cycle and records a pending request.
- R2: A frame boundary is a 1-to-0 transition of `vsync_in`, seen after `SYNC_STAGES` synchroniser flops. A 0-to-1 transition of `vsync_in` changes neither `wr_en` nor `busy`.
- R3: At a boundary with a request pending, `wr_en` becomes 1, the completion flag is cleared and the pending request is consumed. `wr_en` never changes except at a boundary.
- R4: At a boundary with no request pending, `wr_en` becomes 0. If `busy` was 1 and no new request arrives in that cycle, `busy` becomes 0 and the completion flag becomes 1.
- R5: Each 0-to-1 transition of `href_in` increments the line counter. The counter saturates at 2^`LINE_W`-1.
- R6: At every boundary the line count is copied to `last_lines` and the counter restarts from zero.
- R7: One cycle after a `done_rd` pulse, `done_rd_data` shows the completion flag if `busy` is 0, and shows 0 if `busy` is 1. A query made while not busy also clears the flag, so a second query returns 0.
- R8: `done` is 1 only when the completion flag is set and `busy` is 0.
- R9: During and after reset, `wr_en`, `busy`, `done`, `done_rd_data` and `last_lines` are all 0, and no request is pending.
- R10: A request that arrives in the same cycle as a boundary does not start a capture at that boundary. It is held, and it raises `wr_en` at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Raw vertical sync; its falling edge marks a frame boundary |
| href_in | input | 1 | Raw horizontal reference; its rising edge marks a line start |
| cap_req | input | 1 | Single-cycle capture request |
| done_rd | input | 1 | Single-cycle completion query strobe |
| wr_en | output | 1 | FIFO write-enable, high for one captured frame |
| busy | output | 1 | A capture is requested or in progress |
| done | output | 1 | Completion flag, masked while busy |
| done_rd_data | output | 1 | Answer to the previous cycle's query |
| last_lines | output | LINE_W | Line total of the last completed frame |

## Verification
The bench covers the following cases, and what a faulty design would show in each:
- **Request in the boundary cycle.** A request is timed to land in exactly the cycle a boundary is detected. A design that reads the incoming request instead of the stored one would open the FIFO one frame early.
- **Rising vsync edge.** Only a rising edge is applied to vsync while a capture is armed. A design with the wrong edge polarity would raise `wr_en` there.
- **Completion while a new request is busy.** The completion flag is left set and a new request is then issued. A design that does not mask the flag would report completion while the new capture is still busy.
- **Repeated query.** Two queries are made back to back. A design that does not clear the flag on a read would answer 1 twice.
- **Line totals.** The frame-length vectors include empty frames and a frame longer than the counter can hold. A design that wraps instead of saturating, or that fails to restart at each boundary, would report the wrong totals.

// File: rtl/fca_pkg.sv
package fca_pkg;
   // Action taken by the controller in the current cycle
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,  // no boundary this cycle
      ACT_START  = 2'd1,  // boundary, request pending: open write window
      ACT_FINISH = 2'd2,  // boundary, capture running: close and report
      ACT_IDLE   = 2'd3   // boundary, nothing armed
   } bnd_act_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_LINE_W      = 24;
endpackage

// File: rtl/fca_sync_edge.sv
module fca_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   import fca_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("fca_sync_edge: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev_q;
   assign fall = ~chain[STAGES-1] & prev_q;

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R2
   AST_NO_DOUBLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R2
endmodule

// File: rtl/fca_line_count.sv
module fca_line_count #(
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              frame_bnd,
   output logic [LINE_W-1:0] last_lines
);
   import fca_pkg::*;

   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

   if (LINE_W < 1 || LINE_W > MAX_LINE_W) begin : g_bad_width
      $error("fca_line_count: LINE_W out of range");
   end

   logic [LINE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         last_lines <= '0;
      end else if (frame_bnd) begin
         last_lines <= cnt_q;
         cnt_q      <= '0;
      end else if (line_start && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bnd |=> (cnt_q == '0)); // R6
   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !frame_bnd) |=> (cnt_q == CNT_MAX)); // R5
endmodule

// File: rtl/fca_cap_ctrl.sv
module fca_cap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_bnd,
   input  logic cap_req,
   input  logic done_rd,
   output logic wr_en,
   output logic busy,
   output logic done,
   output logic done_rd_data
);
   import fca_pkg::*;

   logic     pend_q, busy_q, done_q, we_q, rd_q;
   bnd_act_t act;

   always_comb begin
      if (!frame_bnd)  act = ACT_NONE;
      else if (pend_q) act = ACT_START;
      else if (busy_q) act = ACT_FINISH;
      else             act = ACT_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         we_q   <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         rd_q <= done_rd & ~busy_q & done_q;
         unique case (act)
            ACT_START: begin
               we_q   <= 1'b1;
               done_q <= 1'b0;
               pend_q <= cap_req;
            end
            ACT_FINISH: begin
               we_q   <= 1'b0;
               pend_q <= cap_req;
               if (!cap_req) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
            ACT_IDLE: begin
               we_q   <= 1'b0;
               pend_q <= cap_req;
               busy_q <= busy_q | cap_req;
               if (done_rd && !busy_q) done_q <= 1'b0;
            end
            default: begin
               pend_q <= pend_q | cap_req;
               busy_q <= busy_q | cap_req;
               if (done_rd && !busy_q) done_q <= 1'b0;
            end
         endcase
      end
   end

   assign wr_en        = we_q;
   assign busy         = busy_q;
   assign done         = done_q & ~busy_q;
   assign done_rd_data = rd_q;

   AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req |=> busy_q); // R1
   AST_WE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_bnd |=> $stable(we_q)); // R3
   AST_DONE_FROM_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(frame_bnd)); // R4
   AST_QUERY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_rd && busy_q) |=> !rd_q); // R7
   AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_q) |-> busy_q); // R3
endmodule

// File: rtl/frame_capture_arm.sv
module frame_capture_arm #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LINE_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              href_in,
   input  logic              cap_req,
   input  logic              done_rd,
   output logic              wr_en,
   output logic              busy,
   output logic              done,
   output logic              done_rd_data,
   output logic [LINE_W-1:0] last_lines
);
   logic vs_rise, vs_fall, hr_rise, hr_fall;

   fca_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_sync (
      .clk(clk), .rst_n(rst_n), .async_in(vsync_in),
      .rise(vs_rise), .fall(vs_fall)
   );

   fca_sync_edge #(.STAGES(SYNC_STAGES)) u_hr_sync (
      .clk(clk), .rst_n(rst_n), .async_in(href_in),
      .rise(hr_rise), .fall(hr_fall)
   );

   fca_line_count #(.LINE_W(LINE_W)) u_lines (
      .clk(clk), .rst_n(rst_n), .line_start(hr_rise),
      .frame_bnd(vs_fall), .last_lines(last_lines)
   );

   fca_cap_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_bnd(vs_fall), .cap_req(cap_req),
      .done_rd(done_rd), .wr_en(wr_en), .busy(busy), .done(done),
      .done_rd_data(done_rd_data)
   );

   AST_VS_RISE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_rise && !cap_req) |=> ($stable(wr_en) && $stable(busy))); // R2
   AST_HR_EDGES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(hr_rise && hr_fall)); // R5
endmodule

// File: tb/frame_capture_arm_tb_top.sv
`timescale 1ns/1ps
module frame_capture_arm_tb_top;
   localparam int LW = 5;
   localparam int NV = 6;
   // per-frame line pulses and expected latched total (saturates at 31)
   localparam int VEC_LINES [NV] = '{0, 1, 7, 31, 40, 3};
   localparam int VEC_EXP   [NV] = '{0, 1, 7, 31, 31, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_in = 1'b0, href_in = 1'b0, cap_req = 1'b0, done_rd = 1'b0;
   logic wr_en, busy, done, done_rd_data;
   logic [LW-1:0] last_lines;
   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   frame_capture_arm #(.SYNC_STAGES(2), .LINE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .href_in(href_in),
      .cap_req(cap_req), .done_rd(done_rd), .wr_en(wr_en), .busy(busy),
      .done(done), .done_rd_data(done_rd_data), .last_lines(last_lines)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic line_pulse();
      @(negedge clk) href_in = 1'b1;
      repeat (2) @(negedge clk);
      href_in = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic vs_rise_only();
      @(negedge clk) vsync_in = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic vs_fall_only();
      @(negedge clk) vsync_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic boundary();
      vs_rise_only();
      vs_fall_only();
   endtask

   task automatic run_frame(input int n);
      for (int i = 0; i < n; i++) line_pulse();
      boundary();
   endtask

   task automatic request();
      @(negedge clk) cap_req = 1'b1;
      @(negedge clk) cap_req = 1'b0;
   endtask

   task automatic query(input string req, input int exp);
      @(negedge clk) done_rd = 1'b1;
      @(negedge clk) done_rd = 1'b0;
      chk(req, int'(done_rd_data), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      chk("R9 wr_en", int'(wr_en), 0);
      chk("R9 busy", int'(busy), 0);
      chk("R9 done", int'(done), 0);
      chk("R9 rd_data", int'(done_rd_data), 0);
      chk("R9 last_lines", int'(last_lines), 0);
      @(negedge clk) rst_n = 1'b1;
      boundary();

      // R5 R6: line totals from the vector table
      for (int v = 0; v < NV; v++) begin
         run_frame(VEC_LINES[v]);
         chk("R5/R6 last_lines", int'(last_lines), VEC_EXP[v]);
         chk("R4 idle wr_en", int'(wr_en), 0);
      end

      // R1: request arms busy, write window not yet open
      request();
      chk("R1 busy", int'(busy), 1);
      chk("R3 wr_en before boundary", int'(wr_en), 0);
      query("R7 query while busy", 0);
      // R2: rising vsync edge has no effect
      vs_rise_only();
      chk("R2 rise wr_en", int'(wr_en), 0);
      chk("R2 rise busy", int'(busy), 1);
      vs_fall_only();
      chk("R3 wr_en opened", int'(wr_en), 1);
      chk("R3 busy held", int'(busy), 1);
      chk("R8 done hidden", int'(done), 0);
      run_frame(2);
      chk("R4 wr_en closed", int'(wr_en), 0);
      chk("R4 busy cleared", int'(busy), 0);
      chk("R8 done shown", int'(done), 1);
      chk("R6 captured frame lines", int'(last_lines), 2);

      // R8 R7: completion masked by a new request
      request();
      chk("R8 done masked", int'(done), 0);
      query("R7 masked query", 0);
      boundary();
      chk("R3 second window", int'(wr_en), 1);
      chk("R3 done cleared at start", int'(done), 0);
      boundary();
      chk("R4 second close", int'(done), 1);
      query("R7 first query", 1);
      query("R7 cleared by read", 0);
      chk("R7 done after read", int'(done), 0);

      // R10: request in the same cycle as the boundary is held
      @(negedge clk) vsync_in = 1'b1;
      repeat (5) @(negedge clk);
      vsync_in = 1'b0;
      @(negedge clk);
      @(negedge clk) cap_req = 1'b1;
      @(negedge clk) cap_req = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 not started", int'(wr_en), 0);
      chk("R10 busy", int'(busy), 1);
      boundary();
      chk("R10 started next", int'(wr_en), 1);
      boundary();
      chk("R10 closed", int'(wr_en), 0);
      chk("R10 done", int'(done), 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule